// File: doc/BRIEF.md
# Ring and Johnson Sequence Counter

A four-stage shift-chain counter that runs as either a ring counter or a twisted-ring (Johnson) counter. A static mode input picks the wrap-around path. In ring mode the last stage feeds the first unchanged, so a single 1 travels along the chain and the counter has four states. In Johnson mode the last stage is inverted on its way back to the first, which gives an eight-state sequence.

On every enabled clock the first stage takes the wrap-around bit and each other stage takes the old value of the stage before it. A synchronous initialize input loads the start pattern for the selected mode.

Ring mode has a built-in repair path. A ring state that does not hold exactly one 1 is replaced by the ring start pattern on the next clock, so the counter cannot stay locked in a bad pattern. The design is a small control machine that picks one of four named actions on each clock:

- SEED: load the start pattern.
- REPAIR: restore the ring start pattern.
- STEP: shift by one stage.
- HOLD: keep the state.

A generated chain of stage flops carries out the chosen action. The transitions are:

- init high leads to SEED.
- Otherwise, a non-one-hot state in ring mode leads to REPAIR.
- Otherwise, enable high leads to STEP.
- Otherwise the action is HOLD.

Top module: `seqc_counter`

## Requirements
- R1: While rst_n is low the stage outputs read 1000, with stage_q[3] as the first stage and stage_q[0] as the last. Patterns in this list are written from stage_q[3] down to stage_q[0].
- R2: In ring mode (twist_mode = 0), with enable high and init low, a one-hot state advances on each clock through 1000, 0100, 0010, 0001 and then back to 1000.
- R3: In Johnson mode (twist_mode = 1), with enable high and init low, the state advances on each clock through 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001 and then back to 0000.
- R4: When init is high at a clock edge, the state becomes 1000 in ring mode and 0000 in Johnson mode, whatever the value of enable and whatever the state before.
- R5: With init and enable both low, a legal state holds. Every state is legal in Johnson mode; in ring mode a legal state is one-hot.
- R6: In ring mode with init low, any state whose number of 1s is not exactly one becomes 1000 on the next clock, whether enable is high or low.
- R7: Johnson mode applies no repair. Any state s, one-hot or not, steps to {~s[0], s[3:1]} when enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| twist_mode | input | 1 | 0 selects ring mode, 1 selects Johnson mode |
| init | input | 1 | Synchronous load of the mode's start pattern |
| enable | input | 1 | Allows the chain to advance |
| stage_q | output | STAGES (4) | Stage values; bit 3 is the first stage |

## Verification
The hardest situation to reach from the ports is a ring-mode state that is not one-hot. Reset and initialize only ever produce legal patterns, so the repair path needs another route in. The bench gets there by switching twist_mode from Johnson to ring at points in the Johnson sequence such as 0000, 1100 and 1110, with enable both low and high. It then checks that 1000 appears one clock later. The reverse switch, ring to Johnson at 0100, drives a pattern the Johnson sequence never produces, which shows that Johnson mode shifts it on without repair.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

    // Action chosen by the control machine for the coming clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_STEP   = 2'd1,
        ACT_REPAIR = 2'd2,
        ACT_SEED   = 2'd3
    } act_e;

    // Wrap-around path selection.
    typedef enum logic {
        WRAP_RING  = 1'b0,
        WRAP_TWIST = 1'b1
    } wrap_e;

endpackage

// File: rtl/seqc_loop.sv
// Feedback and legality logic: wrap-around bit, start pattern, state check.
module seqc_loop
    import seqc_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic [STAGES-1:0] state_i,
    input  wrap_e             mode_i,
    output logic              feed_o,
    output logic              legal_o,
    output logic [STAGES-1:0] seed_o
);
    localparam logic [STAGES-1:0] RING_SEED  = {1'b1, {(STAGES-1){1'b0}}};
    localparam logic [STAGES-1:0] TWIST_SEED = '0;

    logic [$clog2(STAGES+1)-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < STAGES; i++) begin
            ones = ones + {{($clog2(STAGES+1)-1){1'b0}}, state_i[i]};
        end
    end

    always_comb begin
        unique case (mode_i)
            WRAP_RING: begin
                feed_o  = state_i[0];
                legal_o = (ones == 1);
                seed_o  = RING_SEED;
            end
            WRAP_TWIST: begin
                feed_o  = ~state_i[0];
                legal_o = 1'b1;
                seed_o  = TWIST_SEED;
            end
            default: begin
                feed_o  = 1'b0;
                legal_o = 1'b0;
                seed_o  = RING_SEED;
            end
        endcase
    end

endmodule

// File: rtl/seqc_ctrl.sv
// Control machine: picks the action for the next edge.
module seqc_ctrl
    import seqc_pkg::*;
(
    input  logic init_i,
    input  logic enable_i,
    input  logic legal_i,
    output act_e act_o
);
    always_comb begin
        unique case ({init_i, legal_i, enable_i})
            3'b100, 3'b101, 3'b110, 3'b111: act_o = ACT_SEED;
            3'b000, 3'b001:                 act_o = ACT_REPAIR;
            3'b011:                         act_o = ACT_STEP;
            3'b010:                         act_o = ACT_HOLD;
            default:                        act_o = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/seqc_chain.sv
// Generated chain of stage flops; bit STAGES-1 is the first stage.
module seqc_chain
    import seqc_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act_i,
    input  logic              feed_i,
    input  logic [STAGES-1:0] seed_i,
    output logic [STAGES-1:0] state_o
);
    localparam logic [STAGES-1:0] RESET_PAT  = {1'b1, {(STAGES-1){1'b0}}};
    localparam logic [STAGES-1:0] REPAIR_PAT = {1'b1, {(STAGES-1){1'b0}}};

    logic [STAGES-1:0] shift_in;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == STAGES - 1) begin : g_head
            assign shift_in[i] = feed_i;
        end else begin : g_body
            assign shift_in[i] = state_o[i+1];
        end

        logic next_bit;

        always_comb begin
            unique case (act_i)
                ACT_SEED:   next_bit = seed_i[i];
                ACT_REPAIR: next_bit = REPAIR_PAT[i];
                ACT_STEP:   next_bit = shift_in[i];
                ACT_HOLD:   next_bit = state_o[i];
                default:    next_bit = state_o[i];
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_o[i] <= RESET_PAT[i];
            else        state_o[i] <= next_bit;
        end
    end

endmodule

// File: rtl/seqc_counter.sv
// Ring / Johnson sequence counter top.
module seqc_counter
    import seqc_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              twist_mode,
    input  logic              init,
    input  logic              enable,
    output logic [STAGES-1:0] stage_q
);
    localparam logic [STAGES-1:0] RING_START = {1'b1, {(STAGES-1){1'b0}}};

    wrap_e             mode;
    act_e              act;
    logic              feed;
    logic              legal;
    logic [STAGES-1:0] seed;

    assign mode = wrap_e'(twist_mode);

    seqc_loop #(.STAGES(STAGES)) u_loop (
        .state_i (stage_q),
        .mode_i  (mode),
        .feed_o  (feed),
        .legal_o (legal),
        .seed_o  (seed)
    );

    seqc_ctrl u_ctrl (
        .init_i   (init),
        .enable_i (enable),
        .legal_i  (legal),
        .act_o    (act)
    );

    seqc_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act),
        .feed_i  (feed),
        .seed_i  (seed),
        .state_o (stage_q)
    );

    // R4: initialize loads the start pattern of the mode in force.
    a_r4_init_load: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (stage_q == ($past(twist_mode) ? '0 : RING_START)));

    // R2: a one-hot ring state rotates toward the last stage.
    a_r2_ring_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && enable && !twist_mode && $countones(stage_q) == 1)
        |=> (stage_q == {$past(stage_q[0]), $past(stage_q[STAGES-1:1])}));

    // R3 and R7: Johnson mode shifts in the inverted last stage.
    a_r3_twist_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && enable && twist_mode)
        |=> (stage_q == {~$past(stage_q[0]), $past(stage_q[STAGES-1:1])}));

    // R5: a legal state holds while init and enable are low.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !enable && (twist_mode || $countones(stage_q) == 1))
        |=> $stable(stage_q));

    // R6: a ring state that is not one-hot is repaired on the next clock.
    a_r6_repair: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !twist_mode && $countones(stage_q) != 1)
        |=> (stage_q == RING_START));

    // R2: after any non-init ring-mode clock the state is one-hot.
    a_r2_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (!twist_mode) |=> ($countones(stage_q) == 1) || $past(init));

endmodule

// File: tb/seqc_counter_bench.sv
module seqc_counter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       twist_mode = 1'b0;
    logic       init = 1'b0;
    logic       enable = 1'b0;
    logic [3:0] stage_q;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t      sb[$];
    logic [3:0] model = 4'b1000;

    always #2 clk = ~clk;   // 250 MHz

    seqc_counter u_seqc_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .twist_mode (twist_mode),
        .init       (init),
        .enable     (enable),
        .stage_q    (stage_q)
    );

    function automatic logic [3:0] next_of(logic [3:0] s, bit in_init, bit en, bit mode);
        if (in_init)                       return mode ? 4'b0000 : 4'b1000;
        if (!mode && $countones(s) != 1)   return 4'b1000;
        if (en)                            return mode ? {~s[0], s[3:1]} : {s[0], s[3:1]};
        return s;
    endfunction

    // Driver: at the falling edge set inputs and queue the expected state.
    task automatic drive(bit in_init, bit en, bit mode, string tag);
        @(negedge clk);
        init       = in_init;
        enable     = en;
        twist_mode = mode;
        model      = next_of(model, in_init, en, mode);
        sb.push_back('{exp: model, tag: tag});
        @(posedge clk);
    endtask

    // Monitor: one ns after each rising edge, compare against the queue head.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_vec++;
            if (stage_q !== it.exp) begin
                n_bad++;
                $display("FAIL %s: stage_q=%b expected=%b", it.tag, stage_q, it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset value
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (stage_q !== 4'b1000) begin
            n_bad++;
            $display("FAIL R1: stage_q=%b expected=1000", stage_q);
        end
        rst_n = 1'b1;

        // R2: ring rotation, more than one lap
        for (int k = 0; k < 6; k++) drive(0, 1, 0, "R2");
        // R5: ring hold
        for (int k = 0; k < 3; k++) drive(0, 0, 0, "R5");
        // R2: enable toggling
        drive(0, 1, 0, "R2");
        drive(0, 0, 0, "R5");
        drive(0, 1, 0, "R2");
        // R4: init in ring mode with enable high
        drive(1, 1, 0, "R4");
        drive(0, 1, 0, "R2");

        // R4: init into Johnson mode
        drive(1, 0, 1, "R4");
        // R3: full Johnson cycle and beyond
        for (int k = 0; k < 10; k++) drive(0, 1, 1, "R3");
        // R5: Johnson hold on a non-one-hot state
        for (int k = 0; k < 2; k++) drive(0, 0, 1, "R5");

        // R6: reach 1100 in Johnson, switch to ring with enable low
        drive(1, 0, 1, "R4");
        drive(0, 1, 1, "R3");
        drive(0, 1, 1, "R3");
        drive(0, 0, 0, "R6");
        drive(0, 0, 0, "R5");
        // R6: Johnson 0000 switched to ring with enable high
        drive(1, 0, 1, "R4");
        drive(0, 1, 0, "R6");
        drive(0, 1, 0, "R2");
        // R6: Johnson 1110 switched to ring with enable high
        drive(1, 0, 1, "R4");
        for (int k = 0; k < 3; k++) drive(0, 1, 1, "R3");
        drive(0, 1, 0, "R6");

        // R7: ring 0100 switched to Johnson shifts without repair
        drive(1, 0, 0, "R4");
        drive(0, 1, 0, "R2");
        for (int k = 0; k < 4; k++) drive(0, 1, 1, "R7");
        // R4: init wins over a Johnson step
        drive(1, 1, 1, "R4");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule